// File: doc/BRIEF.md
# Configurable 8/16-bit Timer Counter

This block is a timer/counter that counts either as a single 16-bit register or as an 8-bit register. A three-bit mode field in its control register picks the count width. It also picks one of three ways of running: free running, clear when the count meets a compare value, or free running while latching the count on a capture edge. The counter advances on each cycle in which the external prescaler strobe `tickEn` is high, as long as the clock-select field is nonzero and the mode is legal.

Software reaches the block through an 8-bit register port with a 3-bit address and single-cycle writes. Reads are combinational. Through this port it can load and read the count, set two 8-bit compare bytes, read the captured count, and clear the event flags. The overflow flag is gated with an enable bit to form the interrupt request `irq`.

Top module: `timer8x16`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: Register addresses are 0 count low, 1 count high, 2 compare A, 3 compare B, 4 capture low, 5 capture high, 6 flags, and 7 control. In the flags register, bit 0 is overflow and bit 1 is capture. In the control register, bits 2:0 are the mode, bits 5:3 are clock select, and bit 6 is the overflow interrupt enable.
- R3: The mode bits are {capture enable, wide, clear-on-match}. 000 is 8-bit normal with TOP 0xFF. 001 is 8-bit CTC with TOP equal to compare A. 010 is 16-bit normal with TOP 0xFFFF. 011 is 16-bit CTC with TOP equal to {compare B, compare A}. 100 is 8-bit capture with TOP 0xFF. 110 is 16-bit capture with TOP 0xFFFF.
- R4: On each enabled tick the count increments by one. A tick taken while the count equals TOP returns it to zero. A count above TOP runs on to MAX and then wraps to zero.
- R5: While clock select is zero, or the mode is 101 or 111, the count holds its value. It can still be read and written.
- R6: A write to a count byte takes effect in place of any increment or clear in that cycle.
- R7: The overflow flag sets on a tick taken while the count equals MAX (0xFF when 8-bit, 0xFFFF when 16-bit), whatever TOP is.
- R8: Writing 1 to a flag bit clears it, and writing 0 has no effect. A flag event in the same cycle as a clear leaves the flag set.
- R9: `irq` equals the overflow flag ANDed with the interrupt enable bit.
- R10: In 8-bit modes the count high byte reads 0x00, and writes to it are ignored.
- R11: In the capture modes, a rising edge on `capIn` is synchronized through two flops. The count is then latched into the capture register, and the capture flag is set, on the third rising clock edge after `capIn` rises.
- R12: Outside the capture modes, edges on `capIn` change neither the capture register nor the capture flag.
- R13: A compare write takes effect on the next tick, with no buffering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Prescaled timer clock enable |
| capIn | input | 1 | Asynchronous capture trigger |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Combinational read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
A register write or a tick becomes visible one clock edge after the edge that takes it, and read data follows the address with no delay. The bench therefore drives inputs at falling edges and reads at the next falling edge. Runs of ticks are framed by raising `tickEn` at one falling edge and dropping it exactly N falling edges later, so the count has moved by exactly N. A capture lands on the third rising edge after `capIn` rises, so the bench waits exactly three edges before it reads the capture registers. This makes a synchronizer one stage too short or too long show up as a wrong value or flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CNTL = 3'd0, A_CNTH = 3'd1, A_CMPA = 3'd2, A_CMPB = 3'd3,
    A_CAPL = 3'd4, A_CAPH = 3'd5, A_FLAG = 3'd6, A_CTRL = 3'd7
  } regAddr_t;

  typedef struct packed {
    logic              tick;
    logic              wrLo;
    logic              wrHi;
    logic [BYTE_W-1:0] wrByte;
    logic              wide;
    logic              capMode;
    logic [CNT_W-1:0]  top;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  capVal,
  input  logic              ovfEvt,
  input  logic              capEvt,
  output strobe_t           strb,
  output logic [BYTE_W-1:0] busRdData,
  output logic              ovfFlag,
  output logic              capFlag,
  output logic              irq
);
  logic [BYTE_W-1:0] ctrlReg, cmpA, cmpB;
  logic [2:0] modeBits, clkSel;
  logic ovfIe, reservedMode, ctcMode, wideMode, capMode;
  logic flagWr;

  assign modeBits     = ctrlReg[2:0];
  assign clkSel       = ctrlReg[5:3];
  assign ovfIe        = ctrlReg[6];
  assign reservedMode = modeBits[2] & modeBits[0];
  assign wideMode     = modeBits[1];
  assign ctcMode      = modeBits[0] & ~modeBits[2];
  assign capMode      = modeBits[2] & ~modeBits[0];
  assign flagWr       = busWr && (busAddr == A_FLAG);

  always_comb begin
    strb         = '0;
    strb.tick    = tickEn & (|clkSel) & ~reservedMode;
    strb.wrLo    = busWr && (busAddr == A_CNTL);
    strb.wrHi    = busWr && (busAddr == A_CNTH);
    strb.wrByte  = busWrData;
    strb.wide    = wideMode;
    strb.capMode = capMode;
    if (ctcMode)
      strb.top = wideMode ? {cmpB, cmpA} : {{BYTE_W{1'b0}}, cmpA};
    else
      strb.top = wideMode ? {CNT_W{1'b1}} : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      cmpA    <= '0;
      cmpB    <= '0;
      ovfFlag <= 1'b0;
      capFlag <= 1'b0;
    end else begin
      if (busWr && busAddr == A_CTRL) ctrlReg <= busWrData;
      if (busWr && busAddr == A_CMPA) cmpA <= busWrData;
      if (busWr && busAddr == A_CMPB) cmpB <= busWrData;
      ovfFlag <= ovfEvt | (ovfFlag & ~(flagWr & busWrData[0]));
      capFlag <= capEvt | (capFlag & ~(flagWr & busWrData[1]));
    end
  end

  always_comb begin
    unique case (busAddr)
      A_CNTL:  busRdData = cnt[BYTE_W-1:0];
      A_CNTH:  busRdData = wideMode ? cnt[CNT_W-1:BYTE_W] : '0;
      A_CMPA:  busRdData = cmpA;
      A_CMPB:  busRdData = cmpB;
      A_CAPL:  busRdData = capVal[BYTE_W-1:0];
      A_CAPH:  busRdData = capVal[CNT_W-1:BYTE_W];
      A_FLAG:  busRdData = {{(BYTE_W-2){1'b0}}, capFlag, ovfFlag};
      default: busRdData = ctrlReg;
    endcase
  end

  assign irq = ovfFlag & ovfIe;
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             capIn,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] capVal,
  output logic             ovfEvt,
  output logic             capEvt
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] syncChain;
  logic [CNT_W-1:0] cntMasked, cntNext;
  logic atTop, atMax, cpuWr;

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= capIn;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  assign capEvt    = strb.capMode & syncChain[CHAIN-2] & ~syncChain[CHAIN-1];
  assign cntMasked = strb.wide ? cnt : {{BYTE_W{1'b0}}, cnt[BYTE_W-1:0]};
  assign atTop     = (cntMasked == strb.top);
  assign atMax     = strb.wide ? (&cnt) : (&cnt[BYTE_W-1:0]);
  assign cpuWr     = strb.wrLo | strb.wrHi;
  assign ovfEvt    = strb.tick & ~cpuWr & atMax;

  always_comb begin
    cntNext = cntMasked;
    if (strb.wrLo)
      cntNext[BYTE_W-1:0] = strb.wrByte;
    else if (strb.wrHi) begin
      if (strb.wide) cntNext[CNT_W-1:BYTE_W] = strb.wrByte;
    end else if (strb.tick) begin
      if (atTop) cntNext = '0;
      else if (strb.wide) cntNext = cnt + 1'b1;
      else cntNext = {{BYTE_W{1'b0}}, cnt[BYTE_W-1:0] + 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      capVal <= '0;
    end else begin
      cnt <= cntNext;
      if (capEvt) capVal <= cntMasked;
    end
  end
endmodule

// File: rtl/timer8x16.sv
module timer8x16
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              capIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  output logic              irq
);
  strobe_t          strb;
  logic [CNT_W-1:0] cnt, capVal;
  logic             ovfEvt, capEvt, ovfFlag, capFlag;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .cnt(cnt), .capVal(capVal), .ovfEvt(ovfEvt),
    .capEvt(capEvt), .strb(strb), .busRdData(busRdData), .ovfFlag(ovfFlag),
    .capFlag(capFlag), .irq(irq)
  );

  tmr_dp #(.SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .capIn(capIn), .cnt(cnt),
    .capVal(capVal), .ovfEvt(ovfEvt), .capEvt(capEvt)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [BYTE_W-1:0] busWrData,
  input logic [CNT_W-1:0]  cnt,
  input strobe_t           strb,
  input logic              ovfFlag,
  input logic              capFlag,
  input logic [CNT_W-1:0]  capVal
);
  AST_CPU_WR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_CNTL) |=> cnt[BYTE_W-1:0] == $past(busWrData)); // R6

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.wrLo) |=> $stable(cnt[BYTE_W-1:0])); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(busWr && busAddr == A_FLAG && busWrData[0])) |=> ovfFlag); // R8

  AST_HI_ZERO_NARROW: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wide |=> cnt[CNT_W-1:BYTE_W] == '0); // R10

  AST_NO_CAP_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capMode && !(busWr && busAddr == A_FLAG && busWrData[1]))
      |=> (capFlag == $past(capFlag)) && $stable(capVal)); // R12

  AST_WRAP_AT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.wrLo && !strb.wrHi && cnt == strb.top) |=> cnt == '0); // R4
endmodule

bind timer8x16 tmr_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
  .cnt(cnt), .strb(strb), .ovfFlag(ovfFlag), .capFlag(capFlag), .capVal(capVal)
);

// File: tb/sim_timer8x16.sv
module sim_timer8x16;
  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0, capIn = 1'b0, busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0, busRdData;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  timer8x16 u0 (.clk(clk), .rstN(rstN), .tickEn(tickEn), .capIn(capIn),
    .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
    .busRdData(busRdData), .irq(irq));

  // {mode, cmpA, cmpB, start, ticks, expCnt, expOvf}
  localparam int NV = 10;
  localparam logic [67:0] VEC [NV] = '{
    {3'b000, 8'h00, 8'h00, 16'h00F0, 16'd20, 16'h0004, 1'b1},  // R4 R7 8-bit wrap
    {3'b000, 8'h00, 8'h00, 16'h0010, 16'd5,  16'h0015, 1'b0},  // R4
    {3'b001, 8'h09, 8'h00, 16'h0000, 16'd25, 16'h0005, 1'b0},  // R3 CTC8
    {3'b010, 8'h00, 8'h00, 16'h00FE, 16'd3,  16'h0101, 1'b0},  // R3 byte carry
    {3'b010, 8'h00, 8'h00, 16'hFFFD, 16'd5,  16'h0002, 1'b1},  // R7 16-bit
    {3'b011, 8'h03, 8'h01, 16'h0100, 16'd10, 16'h0006, 1'b0},  // R3 CTC16
    {3'b100, 8'h00, 8'h00, 16'h00FE, 16'd3,  16'h0001, 1'b1},  // R3 cap8
    {3'b110, 8'h00, 8'h00, 16'h1234, 16'd1,  16'h1235, 1'b0},  // R3 cap16
    {3'b001, 8'hFF, 8'h00, 16'h00FE, 16'd2,  16'h0000, 1'b1},  // R7 TOP=MAX
    {3'b101, 8'h00, 8'h00, 16'h0005, 16'd10, 16'h0005, 1'b0}   // R5 reserved
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic capPulse();
    capIn = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic capRelease();
    capIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi, d;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1", {8'h0, d}, 16'h0);
    end
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // Vector table: R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      v = VEC[i];
      wr(3'd7, {2'b00, 3'b001, v[67:65]});
      wr(3'd2, v[64:57]);
      wr(3'd3, v[56:49]);
      wr(3'd1, v[48:41]);
      wr(3'd0, v[40:33]);
      wr(3'd6, 8'h03);
      ticks(int'(v[32:17]));
      rd(3'd0, lo);
      rd(3'd1, hi);
      chk("R4 count", {hi, lo}, v[16:1]);
      rd(3'd6, d);
      chk("R7 ovf", {15'h0, d[0]}, {15'h0, v[0]});
    end

    // R5 clock select zero stops; count still writable
    wr(3'd7, 8'h00);
    wr(3'd0, 8'h33);
    ticks(5);
    rd(3'd0, d);
    chk("R5 stopped", {8'h0, d}, 16'h0033);

    // R10 high byte ignored in 8-bit mode
    wr(3'd1, 8'h55);
    rd(3'd1, d);
    chk("R10 hi", {8'h0, d}, 16'h0);

    // R6 write beats tick in the same cycle
    wr(3'd7, 8'b00_001_010);
    wr(3'd1, 8'h00);
    tickEn = 1'b1;
    wr(3'd0, 8'h40);
    tickEn = 1'b0;
    rd(3'd0, d);
    chk("R6 write priority", {8'h0, d}, 16'h0040);

    // R13 compare immediately used; R4 count above TOP runs on
    wr(3'd7, 8'b00_001_001);
    wr(3'd0, 8'h20);
    wr(3'd2, 8'h10);
    ticks(3);
    rd(3'd0, d);
    chk("R4 above top", {8'h0, d}, 16'h0023);
    wr(3'd2, 8'h24);
    ticks(2);
    rd(3'd0, d);
    chk("R13 new compare", {8'h0, d}, 16'h0000);

    // R8 write-one-to-clear and set priority; R9 irq
    wr(3'd7, 8'b01_001_000);
    wr(3'd6, 8'h03);
    wr(3'd0, 8'hFF);
    ticks(1);
    chk("R9 irq on", {15'h0, irq}, 16'h1);
    wr(3'd6, 8'h00);
    rd(3'd6, d);
    chk("R8 write zero", {15'h0, d[0]}, 16'h1);
    wr(3'd6, 8'h01);
    rd(3'd6, d);
    chk("R8 cleared", {15'h0, d[0]}, 16'h0);
    chk("R9 irq off", {15'h0, irq}, 16'h0);
    wr(3'd0, 8'hFF);
    tickEn = 1'b1;
    wr(3'd6, 8'h01);
    tickEn = 1'b0;
    rd(3'd6, d);
    chk("R8 set wins", {15'h0, d[0]}, 16'h1);
    wr(3'd7, 8'b00_001_000);
    chk("R9 irq masked", {15'h0, irq}, 16'h0);

    // R11 capture in 16-bit capture mode
    wr(3'd7, 8'b00_001_110);
    wr(3'd6, 8'h03);
    wr(3'd1, 8'hAB);
    wr(3'd0, 8'hCD);
    capPulse();
    rd(3'd4, lo);
    rd(3'd5, hi);
    chk("R11 capture value", {hi, lo}, 16'hABCD);
    rd(3'd6, d);
    chk("R11 capture flag", {15'h0, d[1]}, 16'h1);
    capRelease();

    // R11 capture in 8-bit capture mode
    wr(3'd7, 8'b00_001_100);
    wr(3'd6, 8'h02);
    wr(3'd0, 8'h77);
    capPulse();
    rd(3'd4, lo);
    rd(3'd5, hi);
    chk("R11 capture 8-bit", {hi, lo}, 16'h0077);
    capRelease();

    // R12 no capture outside the capture modes
    wr(3'd7, 8'b00_001_010);
    wr(3'd6, 8'h02);
    wr(3'd0, 8'h11);
    capPulse();
    rd(3'd4, lo);
    rd(3'd5, hi);
    chk("R12 capture unchanged", {hi, lo}, 16'h0077);
    rd(3'd6, d);
    chk("R12 capture flag", {15'h0, d[1]}, 16'h0);
    capRelease();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule